// File: doc/BRIEF.md
# Multi-Lane Read Mode Controller

This block sits behind the serial front end of a serial flash device. When the front end has shifted in a command byte, it pulses a strobe. The controller then decodes the byte and decides whether the transfer is a single-lane command or one of the multi-lane fast reads.

For a multi-lane read, the controller tracks the address, dummy and data phases from the front end's clock counter. It reports how many bits move on each serial clock. In the data phase it drives the output enables and the bit values of up to four IO pins, MSB first within each lane group. It also presents the incoming pin values, masked to the active lane count, to the address shifter.

Four-lane reads take over the write-protect and hold pins as IO2 and IO3. They are accepted only when the quad-enable configuration bit is set. While four lanes are in use, the controller tells the front end to disable hold handling. Deselecting the device returns every pin to input at once.

Top module: `mlr_ctrl`

## Requirements
- R1: One clock edge after `opc_valid` with `cs_n` low, `mode_o` shows the decoded opcode. The codes are 3Bh→1 (dual output), BBh→2 (dual I/O), 6Bh→3 (quad output), and EBh, E7h, E3h→4 (quad I/O). Any other opcode gives 0 (none).
- R2: A quad opcode (6Bh, EBh, E7h, E3h) latched while `qe_bit` is 0 gives `mode_o`=0 and sets `bad_cmd`. `bad_cmd` stays set until `cs_n` rises. With `qe_bit` at 1, the quad opcode is accepted and `bad_cmd` stays 0.
- R3: `hold_dis` is 1 exactly while mode 3 or 4 is held and `cs_n` is low.
- R4: `phase_cnt` counts serial clocks after the opcode, starting from 0. The address phase (`phase_o`=1) lasts 24 clocks for modes 1 and 3, 12 clocks for mode 2, and 6 clocks for mode 4. `lane_cnt` is 1, 2 or 4 in that phase; it is 2 only for mode 2 and 4 only for mode 4. With mode 0, `phase_o`=0 and `lane_cnt`=1.
- R5: The dummy phase (`phase_o`=2) follows the address phase. It lasts 8 clocks for modes 1 and 3, and 4 clocks for modes 2 and 4. The data phase (`phase_o`=3) begins after it, with `lane_cnt` 2 for modes 1–2 and 4 for modes 3–4.
- R6: `io_oe` is nonzero only in the data phase. It is 4'b0011 in dual modes and 4'b1111 in quad modes.
- R7: Let d be the data clock index. In quad mode, `io_out` carries `tx_byte[7:4]` on even d and `tx_byte[3:0]` on odd d. In dual mode, {`io_out[1]`,`io_out[0]`} carries bits 7:6, 5:4, 3:2, 1:0 for d mod 4 = 0..3. The upper pins are 0 in dual mode, and all pins are 0 while outputs are disabled.
- R8: `rx_bits` equals `io_in` masked to the low `lane_cnt` bits.
- R9: While `cs_n` is high, `io_oe` is 0 in the same cycle. From the next edge, `mode_o` and `bad_cmd` are 0. An `opc_valid` pulse while `cs_n` is high has no effect.
- R10: After reset, `mode_o`, `io_oe`, `hold_dis` and `bad_cmd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, one edge per serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| opc_valid | input | 1 | Strobe: opcode byte is complete |
| opcode | input | 8 | Command byte from the front end |
| qe_bit | input | 1 | Quad-enable configuration bit |
| phase_cnt | input | CNT_W | Serial clocks since the end of the opcode |
| tx_byte | input | 8 | Read data byte to send |
| io_in | input | 4 | Sampled IO pin values |
| io_out | output | 4 | IO pin output values |
| io_oe | output | 4 | IO pin output enables |
| rx_bits | output | 4 | Input bits masked to the active lanes |
| lane_cnt | output | 3 | Bits per clock in the current phase |
| phase_o | output | 2 | 0 idle, 1 address, 2 dummy, 3 data |
| mode_o | output | 3 | Latched read mode code |
| hold_dis | output | 1 | Tell the front end to disable hold handling |
| bad_cmd | output | 1 | Quad opcode rejected because quad enable is clear |

## Verification
`mode_o`, `hold_dis` and `bad_cmd` come from registers. They are due one rising edge after the `opc_valid` or `cs_n` change. The bench therefore drives the strobe on a falling edge and reads these outputs on the falling edge after the next rising edge.

Phase, lane count, enables, pin values and `rx_bits` are combinational from the latched mode and `phase_cnt`. The bench changes `phase_cnt` away from any edge and samples one time unit later, within the same cycle. The R9 check of `io_oe` uses the same-cycle timing; the R9 check of `mode_o` waits for the following edge.

// File: rtl/mlr_pkg.sv
package mlr_pkg;
  typedef enum logic [2:0] {
    RM_NONE     = 3'd0,
    RM_DUAL_OUT = 3'd1,
    RM_DUAL_IO  = 3'd2,
    RM_QUAD_OUT = 3'd3,
    RM_QUAD_IO  = 3'd4
  } rd_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ADDR  = 2'd1,
    PH_DUMMY = 2'd2,
    PH_DATA  = 2'd3
  } phase_e;

  function automatic logic is_quad(input rd_mode_e m);
    return (m == RM_QUAD_OUT) || (m == RM_QUAD_IO);
  endfunction
endpackage

// File: rtl/mlr_decode.sv
module mlr_decode
  import mlr_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic       qe_bit,
  output rd_mode_e   mode,
  output logic       reject
);
  rd_mode_e raw;

  always_comb begin
    unique case (opcode)
      8'h3B:               raw = RM_DUAL_OUT;
      8'hBB:               raw = RM_DUAL_IO;
      8'h6B:               raw = RM_QUAD_OUT;
      8'hEB, 8'hE7, 8'hE3: raw = RM_QUAD_IO;
      default:             raw = RM_NONE;
    endcase
  end

  always_comb begin
    reject = is_quad(raw) && !qe_bit;
    mode   = reject ? RM_NONE : raw;
  end
endmodule

// File: rtl/mlr_phase.sv
module mlr_phase
  import mlr_pkg::*;
#(
  parameter int ADDR_BITS   = 24,
  parameter int CNT_W       = 7,
  parameter int DUMMY_LONG  = 8,
  parameter int DUMMY_SHORT = 4
) (
  input  rd_mode_e         mode,
  input  logic [CNT_W-1:0] cnt,
  output phase_e           phase,
  output logic [1:0]       d_idx
);
  localparam logic [CNT_W-1:0] A1 = CNT_W'(ADDR_BITS);
  localparam logic [CNT_W-1:0] A2 = CNT_W'(ADDR_BITS / 2);
  localparam logic [CNT_W-1:0] A4 = CNT_W'(ADDR_BITS / 4);
  localparam logic [CNT_W-1:0] DL = CNT_W'(DUMMY_LONG);
  localparam logic [CNT_W-1:0] DS = CNT_W'(DUMMY_SHORT);

  logic [CNT_W-1:0] a_end;
  logic [CNT_W-1:0] d_start;

  always_comb begin
    unique case (mode)
      RM_DUAL_OUT, RM_QUAD_OUT: begin a_end = A1; d_start = A1 + DL; end
      RM_DUAL_IO:               begin a_end = A2; d_start = A2 + DS; end
      RM_QUAD_IO:               begin a_end = A4; d_start = A4 + DS; end
      default:                  begin a_end = '0; d_start = '0; end
    endcase
  end

  always_comb begin
    if (mode == RM_NONE)     phase = PH_IDLE;
    else if (cnt < a_end)    phase = PH_ADDR;
    else if (cnt < d_start)  phase = PH_DUMMY;
    else                     phase = PH_DATA;
    d_idx = cnt[1:0] - d_start[1:0];
  end
endmodule

// File: rtl/mlr_lane_map.sv
module mlr_lane_map
  import mlr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  rd_mode_e   mode,
  input  phase_e     phase,
  input  logic [1:0] d_idx,
  input  logic [7:0] tx_byte,
  input  logic [3:0] io_in,
  output logic [3:0] io_out,
  output logic [3:0] io_oe,
  output logic [3:0] rx_bits,
  output logic [2:0] lane_cnt
);
  logic drive;

  always_comb begin
    if (phase == PH_DATA)
      lane_cnt = is_quad(mode) ? 3'd4 : 3'd2;
    else if (mode == RM_QUAD_IO)
      lane_cnt = 3'd4;
    else if (mode == RM_DUAL_IO)
      lane_cnt = 3'd2;
    else
      lane_cnt = 3'd1;
    drive = !cs_n && (phase == PH_DATA);
  end

  for (genvar i = 0; i < 4; i++) begin : g_pin
    assign io_oe[i]   = drive && (3'(i) < lane_cnt);
    assign rx_bits[i] = io_in[i] && (3'(i) < lane_cnt);
  end

  always_comb begin
    io_out = 4'h0;
    if (drive) begin
      if (lane_cnt == 3'd4)
        io_out = d_idx[0] ? tx_byte[3:0] : tx_byte[7:4];
      else
        unique case (d_idx)
          2'd0: io_out = {2'b00, tx_byte[7:6]};
          2'd1: io_out = {2'b00, tx_byte[5:4]};
          2'd2: io_out = {2'b00, tx_byte[3:2]};
          default: io_out = {2'b00, tx_byte[1:0]};
        endcase
    end
  end

  // R6
  oe_only_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe != 4'h0) |-> (phase == PH_DATA));
  // R6
  oe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'h0) || (io_oe == 4'h3) || (io_oe == 4'hF));
  // R7
  idle_pins_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'h0) |-> (io_out == 4'h0));
endmodule

// File: rtl/mlr_ctrl.sv
module mlr_ctrl
  import mlr_pkg::*;
#(
  parameter int ADDR_BITS   = 24,
  parameter int CNT_W       = 7,
  parameter int DUMMY_LONG  = 8,
  parameter int DUMMY_SHORT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             opc_valid,
  input  logic [7:0]       opcode,
  input  logic             qe_bit,
  input  logic [CNT_W-1:0] phase_cnt,
  input  logic [7:0]       tx_byte,
  input  logic [3:0]       io_in,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  output logic [3:0]       rx_bits,
  output logic [2:0]       lane_cnt,
  output logic [1:0]       phase_o,
  output logic [2:0]       mode_o,
  output logic             hold_dis,
  output logic             bad_cmd
);
  rd_mode_e dec_mode, mode_q, mode_d;
  logic     dec_rej, rej_q, rej_d;
  phase_e   phase;
  logic [1:0] d_idx;

  mlr_decode u_dec (.opcode(opcode), .qe_bit(qe_bit), .mode(dec_mode), .reject(dec_rej));

  always_comb begin
    mode_d = mode_q;
    rej_d  = rej_q;
    if (cs_n) begin
      mode_d = RM_NONE;
      rej_d  = 1'b0;
    end else if (opc_valid) begin
      mode_d = dec_mode;
      rej_d  = rej_q | dec_rej;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RM_NONE;
      rej_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      rej_q  <= rej_d;
    end
  end

  mlr_phase #(.ADDR_BITS(ADDR_BITS), .CNT_W(CNT_W), .DUMMY_LONG(DUMMY_LONG),
              .DUMMY_SHORT(DUMMY_SHORT))
    u_ph (.mode(mode_q), .cnt(phase_cnt), .phase(phase), .d_idx(d_idx));

  mlr_lane_map u_map (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .mode(mode_q), .phase(phase),
    .d_idx(d_idx), .tx_byte(tx_byte), .io_in(io_in), .io_out(io_out),
    .io_oe(io_oe), .rx_bits(rx_bits), .lane_cnt(lane_cnt)
  );

  assign phase_o  = phase;
  assign mode_o   = mode_q;
  assign hold_dis = !cs_n && is_quad(mode_q);
  assign bad_cmd  = rej_q;

  // R9
  deselect_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (mode_o == 3'd0) && !bad_cmd);
  // R2
  quad_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && opc_valid && !qe_bit && (opcode == 8'hEB || opcode == 8'h6B))
      |=> bad_cmd && (mode_o == 3'd0));
  // R3
  hold_quad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe[3] |-> hold_dis);
  // R9
  deselect_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (io_oe == 4'h0));
endmodule

// File: tb/test_mlr_ctrl.sv
module test_mlr_ctrl;
  logic clk = 1'b0;
  logic rst_n, cs_n, opc_valid, qe_bit;
  logic [7:0] opcode, tx_byte;
  logic [6:0] phase_cnt;
  logic [3:0] io_in, io_out, io_oe, rx_bits;
  logic [2:0] lane_cnt, mode_o;
  logic [1:0] phase_o;
  logic hold_dis, bad_cmd;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  mlr_ctrl i_mlr_ctrl (.*);

  typedef struct packed {
    logic [7:0] op; logic qe; logic [6:0] cnt; logic [7:0] byt; logic [3:0] iin;
    logic [2:0] md; logic [1:0] ph; logic [2:0] ln; logic [3:0] oe;
    logic [3:0] out; logic [3:0] rx; logic hd; logic il;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{8'h3B,1'b0,7'd0 ,8'hA5,4'hF,3'd1,2'd1,3'd1,4'h0,4'h0,4'h1,1'b0,1'b0},
    '{8'h3B,1'b0,7'd23,8'hA5,4'hF,3'd1,2'd1,3'd1,4'h0,4'h0,4'h1,1'b0,1'b0},
    '{8'h3B,1'b0,7'd24,8'hA5,4'hF,3'd1,2'd2,3'd1,4'h0,4'h0,4'h1,1'b0,1'b0},
    '{8'h3B,1'b0,7'd31,8'hA5,4'hF,3'd1,2'd2,3'd1,4'h0,4'h0,4'h1,1'b0,1'b0},
    '{8'h3B,1'b0,7'd32,8'hA5,4'hF,3'd1,2'd3,3'd2,4'h3,4'h2,4'h3,1'b0,1'b0},
    '{8'h3B,1'b0,7'd35,8'hA5,4'hF,3'd1,2'd3,3'd2,4'h3,4'h1,4'h3,1'b0,1'b0},
    '{8'hBB,1'b0,7'd11,8'h3C,4'h6,3'd2,2'd1,3'd2,4'h0,4'h0,4'h2,1'b0,1'b0},
    '{8'hBB,1'b0,7'd12,8'h3C,4'h6,3'd2,2'd2,3'd2,4'h0,4'h0,4'h2,1'b0,1'b0},
    '{8'hBB,1'b0,7'd15,8'h3C,4'h6,3'd2,2'd2,3'd2,4'h0,4'h0,4'h2,1'b0,1'b0},
    '{8'hBB,1'b0,7'd16,8'h3C,4'h6,3'd2,2'd3,3'd2,4'h3,4'h0,4'h2,1'b0,1'b0},
    '{8'hBB,1'b0,7'd17,8'h3C,4'h6,3'd2,2'd3,3'd2,4'h3,4'h3,4'h2,1'b0,1'b0},
    '{8'h6B,1'b1,7'd0 ,8'hA5,4'hF,3'd3,2'd1,3'd1,4'h0,4'h0,4'h1,1'b1,1'b0},
    '{8'h6B,1'b1,7'd32,8'hA5,4'hF,3'd3,2'd3,3'd4,4'hF,4'hA,4'hF,1'b1,1'b0},
    '{8'h6B,1'b1,7'd33,8'hA5,4'hF,3'd3,2'd3,3'd4,4'hF,4'h5,4'hF,1'b1,1'b0},
    '{8'h6B,1'b0,7'd32,8'hA5,4'hF,3'd0,2'd0,3'd1,4'h0,4'h0,4'h1,1'b0,1'b1},
    '{8'hEB,1'b1,7'd5 ,8'hC3,4'h9,3'd4,2'd1,3'd4,4'h0,4'h0,4'h9,1'b1,1'b0},
    '{8'hEB,1'b1,7'd6 ,8'hC3,4'h9,3'd4,2'd2,3'd4,4'h0,4'h0,4'h9,1'b1,1'b0},
    '{8'hEB,1'b1,7'd9 ,8'hC3,4'h9,3'd4,2'd2,3'd4,4'h0,4'h0,4'h9,1'b1,1'b0},
    '{8'hEB,1'b1,7'd10,8'hC3,4'h9,3'd4,2'd3,3'd4,4'hF,4'hC,4'h9,1'b1,1'b0},
    '{8'hEB,1'b1,7'd11,8'hC3,4'h9,3'd4,2'd3,3'd4,4'hF,4'h3,4'h9,1'b1,1'b0},
    '{8'hE7,1'b1,7'd10,8'h5A,4'h0,3'd4,2'd3,3'd4,4'hF,4'h5,4'h0,1'b1,1'b0},
    '{8'hE3,1'b1,7'd0 ,8'h5A,4'h0,3'd4,2'd1,3'd4,4'h0,4'h0,4'h0,1'b1,1'b0},
    '{8'hE3,1'b0,7'd0 ,8'h5A,4'h0,3'd0,2'd0,3'd1,4'h0,4'h0,4'h0,1'b0,1'b1},
    '{8'h03,1'b1,7'd40,8'h5A,4'hF,3'd0,2'd0,3'd1,4'h0,4'h0,4'h1,1'b0,1'b0},
    '{8'hEB,1'b0,7'd10,8'hC3,4'h9,3'd0,2'd0,3'd1,4'h0,4'h0,4'h1,1'b0,1'b1}
  };

  task automatic chk(input string tag, input int act, input int exp, input int v);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s vector %0d: got %0h expected %0h", tag, v, act, exp);
    end
  endtask

  task automatic latch(input logic [7:0] op, input logic qe);
    @(negedge clk);
    cs_n = 1'b0; opcode = op; qe_bit = qe; opc_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    opc_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; opc_valid = 1'b0; opcode = 8'h00; qe_bit = 1'b0;
    phase_cnt = '0; tx_byte = '0; io_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 mode", int'(mode_o), 0, -1);
    chk("R10 oe", int'(io_oe), 0, -1);
    chk("R10 hold", int'(hold_dis), 0, -1);
    chk("R10 bad", int'(bad_cmd), 0, -1);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      latch(VEC[v].op, VEC[v].qe);
      phase_cnt = VEC[v].cnt; tx_byte = VEC[v].byt; io_in = VEC[v].iin;
      #1;
      chk("R1 mode", int'(mode_o), int'(VEC[v].md), v);
      chk("R2 bad_cmd", int'(bad_cmd), int'(VEC[v].il), v);
      chk("R3 hold_dis", int'(hold_dis), int'(VEC[v].hd), v);
      chk("R4/R5 phase", int'(phase_o), int'(VEC[v].ph), v);
      chk("R4 lanes", int'(lane_cnt), int'(VEC[v].ln), v);
      chk("R6 oe", int'(io_oe), int'(VEC[v].oe), v);
      chk("R7 io_out", int'(io_out), int'(VEC[v].out), v);
      chk("R8 rx_bits", int'(rx_bits), int'(VEC[v].rx), v);
      @(negedge clk);
      cs_n = 1'b1;
      @(negedge clk);
    end

    // R9: deselect mid data phase
    latch(8'h6B, 1'b1);
    phase_cnt = 7'd32; tx_byte = 8'hA5;
    #1;
    chk("R9 oe before", int'(io_oe), 15, 100);
    cs_n = 1'b1;
    #1;
    chk("R9 oe same cycle", int'(io_oe), 0, 101);
    @(negedge clk);
    chk("R9 mode cleared", int'(mode_o), 0, 102);
    chk("R9 hold cleared", int'(hold_dis), 0, 103);
    // R9: strobe while deselected is ignored
    opcode = 8'hBB; opc_valid = 1'b1;
    @(negedge clk);
    opc_valid = 1'b0;
    chk("R9 strobe ignored", int'(mode_o), 0, 104);
    // R2: rejection sticky until deselect
    latch(8'hEB, 1'b0);
    latch(8'h3B, 1'b0);
    chk("R2 sticky bad", int'(bad_cmd), 1, 105);
    chk("R1 relatch mode", int'(mode_o), 1, 106);
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
    chk("R9 bad cleared", int'(bad_cmd), 0, 107);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule